// File: doc/BRIEF.md
# PC Card Socket Status and Control Register Block

This block is the byte-wide register front end for a single PC card socket. It brings the socket's slow, asynchronous signals into the clock domain: the two card-detect lines, the two voltage-sense lines, write protect, ready and the two battery lines. It shows their current levels in a pin status register, turns their edges into sticky change flags, and raises one interrupt line whenever a flag is set whose enable bit is set. It also drives the socket control outputs from two control registers: card reset, output-driver enable, card type, power-management mode and the two supply-select lines.

The card type bit decides how the card's signals are read. For a memory card, a rising edge of ready and falling edges of the two battery lines each set their own flag. For an I/O card, those pins have other meanings: the first battery line carries the card's status-change signal, and a falling ready line is the card's interrupt request. These set two I/O-only flags instead, and the memory flags stay quiet. Software clears flags by writing 0 to them. A 1 leaves a flag alone, so selected flags can be cleared with a read-modify-write.

Register offsets: 0x0 pin status, 0x2 general control, 0x4 change flags, 0x6 change enables, 0x8 supplementary control. All other offsets read 0.

Top module: `pccard_sock_ctl`

## Requirements
- R1: After reset, the change flags and enable bits are 0, general control reads 0x50, supplementary control reads 0x02, card_rst=1, out_drv_en=0, vcc0_sel=1, vcc1_sel=1 and irq=0.
- R2: Only these bits are writable: general control bits 7..3 (mask 0xF8), enable bits 6 and 4..0 (mask 0x5F) and supplementary control bit 1 (mask 0x02). The other bits, and every unmapped offset, read 0. Read data appears on rdata at the clock edge that samples rd_en and is held until the next read.
- R3: The pin status register (offset 0x0) shows the synchronised levels with this layout: bit 0 battery-dead line, bit 1 battery-warning line, bits 3:2 the detect lines, bits 5:4 the active-low voltage-sense lines, bit 6 write protect, bit 7 ready. A pin change is visible within four cycles.
- R4: Any transition of either detect line sets change bit 3, whatever the card type.
- R5: In memory mode (general control bit 5 = 0), a rising ready edge sets change bit 2, a falling battery-dead line sets bit 0, and a falling battery-warning line sets bit 1. A falling ready edge and rising battery edges set nothing.
- R6: In I/O mode (general control bit 5 = 1), a falling battery-dead line (the status-change signal) sets change bit 4 and a falling ready line (the interrupt request) sets bit 5. Change bits 0..2 are not raised.
- R7: Writing 0 to a change bit at offset 0x4 clears it. Writing 1 leaves it unchanged.
- R8: If an event arrives in the same cycle that software writes 0 to its flag, the flag stays set.
- R9: irq is high when any change bit 0..4 is set together with the enable bit in the same position, or when change bit 5 is set and enable bit 6 is set. It stays high until those flags are cleared or disabled.
- R10: card_rst follows general control bit 6, out_drv_en bit 7, io_card bit 5, pwr_mgmt bit 3 and vcc0_sel bit 4, and vcc1_sel follows supplementary bit 1. The supply is off at vcc0/vcc1 = 1/1, 3.3 V at 1/0 and 5 V at 0/0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sk_cd_n | input | 2 | Card-detect lines, both low = card present |
| sk_vs_n | input | 2 | Voltage-sense lines, active low |
| sk_wp | input | 1 | Write-protect line |
| sk_rdy | input | 1 | Ready line (interrupt request for I/O cards) |
| sk_batt_n | input | 2 | Battery lines: [0] dead / status change, [1] warning |
| card_rst | output | 1 | Card reset drive |
| out_drv_en | output | 1 | Socket output-driver enable |
| io_card | output | 1 | Card type, 1 = I/O card |
| pwr_mgmt | output | 1 | Power-management mode |
| vcc0_sel | output | 1 | Supply select line 0 |
| vcc1_sel | output | 1 | Supply select line 1 |
| irq | output | 1 | Change interrupt |

## Verification
The bench builds the block with its defaults: a two-stage synchroniser and a 4-bit offset. With the two-stage synchroniser, the time from a pin change to its flag is a fixed three edges. That lets the bench place a clear write in exactly the cycle an event lands, and so test that the event wins. The 4-bit offset reaches odd and unused offsets as well as the five registers, so unmapped reads are exercised. Random writes and random enable and clear patterns are checked against a model of the bench's own, alongside directed edge sequences in both card modes.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    // register byte offsets
    localparam int OFS_PIN = 'h0;
    localparam int OFS_GCR = 'h2;
    localparam int OFS_CHG = 'h4;
    localparam int OFS_IER = 'h6;
    localparam int OFS_SCR = 'h8;

    // general control bit positions
    localparam int G_PWRM  = 3;
    localparam int G_VCC0  = 4;
    localparam int G_IO    = 5;
    localparam int G_RST   = 6;
    localparam int G_DRV   = 7;
    // supplementary control bit position
    localparam int S_VCC1  = 1;

    // change flag positions (enable bits share 0..4)
    localparam int C_BDEAD = 0;
    localparam int C_BWARN = 1;
    localparam int C_RDY   = 2;
    localparam int C_DET   = 3;
    localparam int C_STS   = 4;
    localparam int C_IREQ  = 5;
    localparam int NUM_EVT = 6;
    localparam int E_IREQ  = 6;

    localparam logic [7:0] GCR_WMASK = 8'hF8;
    localparam logic [7:0] IER_WMASK = 8'h5F;
    localparam logic [7:0] SCR_WMASK = 8'h02;
    localparam logic [7:0] CHG_MASK  = 8'h3F;
    localparam logic [7:0] GCR_RST   = 8'h50;
    localparam logic [7:0] SCR_RST   = 8'h02;

    // socket pin bundle, packed in pin-status register order
    typedef struct packed {
        logic       rdy;
        logic       wp;
        logic [1:0] vs_n;
        logic [1:0] cd_n;
        logic [1:0] batt_n;
    } pin_t;

    typedef struct packed {
        logic [7:0] gcr;
        logic [7:0] scr;
        logic [7:0] ier;
        logic [7:0] chg;
        logic [7:0] rdat;
    } regs_t;

endpackage

// File: rtl/pcs_sync.sv
module pcs_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/pcs_evt.sv
module pcs_evt
    import pcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pin_t               pins,
    input  logic               io_mode,
    output logic [NUM_EVT-1:0] evt
);
    // edges are ignored until the synchroniser and the history register hold real pin values
    localparam int ARM_LIMIT = SYNC_STAGES + 1;
    localparam int CNT_W     = $clog2(ARM_LIMIT + 1);

    typedef struct packed {
        pin_t             prev;
        logic [CNT_W-1:0] arm_cnt;
    } evt_st_t;

    evt_st_t st_d, st_q;
    logic    armed;
    logic    det_tog, rdy_rise, rdy_fall, b0_fall, b1_fall;

    always_comb begin
        armed    = (st_q.arm_cnt == CNT_W'(ARM_LIMIT));
        det_tog  = |(pins.cd_n ^ st_q.prev.cd_n);
        rdy_rise = pins.rdy & ~st_q.prev.rdy;
        rdy_fall = ~pins.rdy & st_q.prev.rdy;
        b0_fall  = ~pins.batt_n[0] & st_q.prev.batt_n[0];
        b1_fall  = ~pins.batt_n[1] & st_q.prev.batt_n[1];

        evt          = '0;
        evt[C_BDEAD] = armed & ~io_mode & b0_fall;
        evt[C_BWARN] = armed & ~io_mode & b1_fall;
        evt[C_RDY]   = armed & ~io_mode & rdy_rise;
        evt[C_DET]   = armed & det_tog;
        evt[C_STS]   = armed & io_mode & b0_fall;
        evt[C_IREQ]  = armed & io_mode & rdy_fall;

        st_d      = st_q;
        st_d.prev = pins;
        if (!armed) st_d.arm_cnt = st_q.arm_cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pccard_sock_ctl.sv
module pccard_sock_ctl
    import pcs_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [1:0]        sk_cd_n,
    input  logic [1:0]        sk_vs_n,
    input  logic              sk_wp,
    input  logic              sk_rdy,
    input  logic [1:0]        sk_batt_n,
    output logic              card_rst,
    output logic              out_drv_en,
    output logic              io_card,
    output logic              pwr_mgmt,
    output logic              vcc0_sel,
    output logic              vcc1_sel,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(OFS_PIN);
    localparam logic [ADDR_W-1:0] A_GCR = ADDR_W'(OFS_GCR);
    localparam logic [ADDR_W-1:0] A_CHG = ADDR_W'(OFS_CHG);
    localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(OFS_IER);
    localparam logic [ADDR_W-1:0] A_SCR = ADDR_W'(OFS_SCR);

    pin_t               raw_pins, pins_s;
    logic [NUM_EVT-1:0] evt;
    regs_t              r_d, r_q;
    logic [7:0]         clr_mask;
    logic               chg_wr;

    assign raw_pins = '{rdy: sk_rdy, wp: sk_wp, vs_n: sk_vs_n,
                        cd_n: sk_cd_n, batt_n: sk_batt_n};

    pcs_sync #(.W($bits(pin_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_pins),
        .dout (pins_s)
    );

    pcs_evt #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins   (pins_s),
        .io_mode(r_q.gcr[G_IO]),
        .evt    (evt)
    );

    always_comb begin
        r_d      = r_q;
        chg_wr   = wr_en && (addr == A_CHG);
        clr_mask = chg_wr ? (~wdata & CHG_MASK) : 8'h00;

        if (wr_en) begin
            case (addr)
                A_GCR:   r_d.gcr = wdata & GCR_WMASK;
                A_IER:   r_d.ier = wdata & IER_WMASK;
                A_SCR:   r_d.scr = wdata & SCR_WMASK;
                default: ;
            endcase
        end

        // a new event outranks a clearing write in the same cycle
        r_d.chg = ((r_q.chg & ~clr_mask) | {{(8-NUM_EVT){1'b0}}, evt}) & CHG_MASK;

        if (rd_en) begin
            case (addr)
                A_PIN:   r_d.rdat = pins_s;
                A_GCR:   r_d.rdat = r_q.gcr;
                A_CHG:   r_d.rdat = r_q.chg;
                A_IER:   r_d.rdat = r_q.ier;
                A_SCR:   r_d.rdat = r_q.scr;
                default: r_d.rdat = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.gcr  <= GCR_RST;
            r_q.scr  <= SCR_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata      = r_q.rdat;
    assign card_rst   = r_q.gcr[G_RST];
    assign out_drv_en = r_q.gcr[G_DRV];
    assign io_card    = r_q.gcr[G_IO];
    assign pwr_mgmt   = r_q.gcr[G_PWRM];
    assign vcc0_sel   = r_q.gcr[G_VCC0];
    assign vcc1_sel   = r_q.scr[S_VCC1];
    assign irq        = (|(r_q.chg[C_STS:0] & r_q.ier[C_STS:0]))
                      | (r_q.chg[C_IREQ] & r_q.ier[E_IREQ]);

    generate
        for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
            // R7
            chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == A_CHG && !wdata[i] && !evt[i]) |=> !r_q.chg[i]);
            // R7
            chg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (r_q.chg[i] && !(wr_en && addr == A_CHG && !wdata[i])) |=> r_q.chg[i]);
            // R8
            chg_event_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
                evt[i] |=> r_q.chg[i]);
        end
        for (genvar j = 0; j <= C_RDY; j++) begin : g_io
            // R6
            io_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (io_card && !r_q.chg[j]) |=> !r_q.chg[j]);
        end
    endgenerate

    // R9
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_IER && wdata == 8'h00) |=> !irq);
endmodule

// File: tb/pccard_sock_ctl_test.sv
`timescale 1ns/1ps
module pccard_sock_ctl_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0, rd_en = 0;
    logic [3:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic [1:0] sk_cd_n = 2'b11, sk_vs_n = 2'b11, sk_batt_n = 2'b11;
    logic       sk_wp = 0, sk_rdy = 1;
    logic       card_rst, out_drv_en, io_card, pwr_mgmt, vcc0_sel, vcc1_sel, irq;
    int         checks = 0, errors = 0;
    logic [7:0] pins = 8'hBF;
    logic [7:0] m_gcr, m_ier, m_scr, m_chg, v;

    always #2 clk = ~clk;

    pccard_sock_ctl uut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pins = p;
        {sk_rdy, sk_wp, sk_vs_n, sk_cd_n, sk_batt_n} = p;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic exp_irq(input logic [7:0] c, input logic [7:0] e);
        return (|(c[4:0] & e[4:0])) | (c[5] & e[6]);
    endfunction

    task automatic chk_outs(input string req);
        chk(req, {2'b0, card_rst, out_drv_en, io_card, pwr_mgmt, vcc0_sel, vcc1_sel},
            {2'b0, m_gcr[6], m_gcr[7], m_gcr[5], m_gcr[3], m_gcr[4], m_scr[1]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (10) @(negedge clk);

        // R1 reset state
        m_gcr = 8'h50; m_scr = 8'h02; m_ier = 0; m_chg = 0;
        chk_outs("R1");
        chk("R1 irq", {7'b0, irq}, 8'h00);
        rd(4'h2, v); chk("R1 gcr", v, 8'h50);
        rd(4'h8, v); chk("R1 scr", v, 8'h02);
        rd(4'h6, v); chk("R1 ier", v, 8'h00);
        rd(4'h4, v); chk("R1 chg", v, 8'h00);

        // R3 pin status layout
        rd(4'h0, v); chk("R3 idle pins", v, 8'hBF);
        for (int i = 0; i < 8; i++) begin
            set_pins(8'($urandom));
            rd(4'h0, v); chk("R3 random pins", v, pins);
        end
        set_pins(8'hBF);
        wr(4'h4, 8'h00);
        rd(4'h4, v); chk("R7 clear all", v, 8'h00);

        // R2 write masks, unmapped offsets, read hold
        wr(4'h6, 8'hFF); rd(4'h6, v); chk("R2 ier mask", v, 8'h5F);
        wr(4'h6, 8'h00);
        rd(4'h1, v); chk("R2 unmapped 1", v, 8'h00);
        rd(4'hC, v); chk("R2 unmapped C", v, 8'h00);
        rd(4'h2, v); repeat (3) @(negedge clk);
        chk("R2 read hold", rdata, 8'h50);
        for (int i = 0; i < 30; i++) begin
            logic [1:0] sel;
            logic [7:0] d;
            sel = 2'($urandom % 3);
            d   = 8'($urandom);
            if (sel == 0) begin wr(4'h2, d); m_gcr = d & 8'hF8; rd(4'h2, v); chk("R2 gcr", v, m_gcr); end
            else if (sel == 1) begin wr(4'h8, d); m_scr = d & 8'h02; rd(4'h8, v); chk("R2 scr", v, m_scr); end
            else begin wr(4'h6, d & 8'hA0); rd(4'h6, v); chk("R2 ier", v, 8'h00 | (d & 8'h00)); end
            chk_outs("R10 outputs");
        end

        // R10 supply encodings
        wr(4'h2, 8'h10); wr(4'h8, 8'h02); m_gcr = 8'h10; m_scr = 8'h02;
        chk("R10 off", {6'b0, vcc0_sel, vcc1_sel}, 8'h03);
        wr(4'h8, 8'h00);
        chk("R10 3v3", {6'b0, vcc0_sel, vcc1_sel}, 8'h02);
        wr(4'h2, 8'h00);
        chk("R10 5v", {6'b0, vcc0_sel, vcc1_sel}, 8'h00);
        wr(4'h6, 8'h00);
        wr(4'h4, 8'h00);

        // R4 detect changes
        set_pins(8'hB7); rd(4'h4, v); chk("R4 one line", v, 8'h08);
        wr(4'h4, 8'hF7); rd(4'h4, v); chk("R7 clear bit3", v, 8'h00);
        set_pins(8'hB3); rd(4'h4, v); chk("R4 second line", v, 8'h08);
        wr(4'h4, 8'h00);

        // R5 memory mode events
        set_pins(8'h33); rd(4'h4, v); chk("R5 ready fall ignored", v, 8'h00);
        set_pins(8'hB3); rd(4'h4, v); chk("R5 ready rise", v, 8'h04);
        set_pins(8'hB2); rd(4'h4, v); chk("R5 batt dead", v, 8'h05);
        set_pins(8'hB0); rd(4'h4, v); chk("R5 batt warn", v, 8'h07);
        wr(4'h4, 8'hFF); rd(4'h4, v); chk("R7 ones keep", v, 8'h07);
        wr(4'h4, 8'hFA); rd(4'h4, v); chk("R7 partial clear", v, 8'h02);
        set_pins(8'hB3); rd(4'h4, v); chk("R5 batt rise ignored", v, 8'h02);
        wr(4'h4, 8'h00);

        // R6 I/O mode events
        wr(4'h2, 8'h20); m_gcr = 8'h20;
        chk("R6 io_card", {7'b0, io_card}, 8'h01);
        set_pins(8'hB2); rd(4'h4, v); chk("R6 status change", v, 8'h10);
        set_pins(8'h32); rd(4'h4, v); chk("R6 ireq fall", v, 8'h30);
        set_pins(8'hB2); rd(4'h4, v); chk("R6 ready rise quiet", v, 8'h30);
        set_pins(8'hB0); rd(4'h4, v); chk("R6 batt warn quiet", v, 8'h30);
        set_pins(8'hB3);

        // R9 masking of flags 4 and 5
        wr(4'h6, 8'h10); chk("R9 bit4 en", {7'b0, irq}, 8'h01);
        wr(4'h6, 8'h40); chk("R9 ireq en bit6", {7'b0, irq}, 8'h01);
        wr(4'h6, 8'h20); chk("R9 bit5 not enable", {7'b0, irq}, 8'h00);
        wr(4'h6, 8'h40); wr(4'h4, 8'hDF);
        chk("R9 cleared ireq", {7'b0, irq}, 8'h00);
        wr(4'h6, 8'h00); wr(4'h4, 8'h00);

        // raise every flag
        wr(4'h2, 8'h00);
        set_pins(8'hB0); set_pins(8'h30); set_pins(8'hB0); set_pins(8'hB4);
        wr(4'h2, 8'h20);
        set_pins(8'hB7); set_pins(8'hB6); set_pins(8'h36);
        m_chg = 8'h3F;
        rd(4'h4, v); chk("R5 R6 all flags", v, m_chg);
        for (int i = 0; i < 20; i++) begin
            m_ier = 8'($urandom) & 8'h5F;
            wr(4'h6, m_ier);
            chk("R9 random enable", {7'b0, irq}, {7'b0, exp_irq(m_chg, m_ier)});
        end
        for (int i = 0; i < 8; i++) begin
            logic [7:0] d;
            d = 8'($urandom) | 8'h80;
            wr(4'h4, d); m_chg = m_chg & d & 8'h3F;
            rd(4'h4, v); chk("R7 random clear", v, m_chg);
            chk("R9 irq after clear", {7'b0, irq}, {7'b0, exp_irq(m_chg, m_ier)});
        end

        // R8 event and clear in the same cycle
        wr(4'h6, 8'h00); wr(4'h4, 8'h00);
        @(negedge clk); sk_cd_n = 2'b00;
        @(negedge clk); @(negedge clk);
        wr_en = 1; addr = 4'h4; wdata = 8'h00;
        @(negedge clk); wr_en = 0;
        rd(4'h4, v); chk("R8 event wins", v, 8'h08);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule